// File: doc/BRIEF.md
# Raw Sensor Pixel Capture Front-End

This block receives pixels from a parallel raw image sensor and passes them on, one pixel per pixel-clock cycle. The sensor supplies a pixel clock, a 12-bit data bus, a line sync (`hsync`, high while a line's pixels are on the bus), a frame sync (`vsync`, whose rising edge starts a frame) and a field ID. The capture logic registers its outputs in the pixel clock domain. It emits a valid strobe, a start-of-line marker and a start-of-frame marker.

A set of control inputs chooses four things:
- which pixel clock edge samples the sensor;
- the pixel width, as a 2-bit code;
- whether the field ID is inverted;
- after how many lines an interrupt is raised.

A channel enable gates capture. The block copies every control input into shadow registers on the frame-sync rising edge, so a frame is always captured with one consistent setting. The line interrupt is counted in the pixel clock domain. It is carried to the system clock by a toggle crossing and appears there as a one-cycle pulse. A zero interval in raw mode is invalid: it raises a sticky error and suppresses interrupts.

Top module: `raw_cap_fe`

## Requirements
- R1: With `cfg_fall`=0, the sensor bus and syncs are sampled on the rising pixel clock edge.
- R2: With `cfg_fall`=1, the sensor bus and syncs are sampled on the falling pixel clock edge.
- R3: In raw mode (`cfg_raw`=1), width code 0 keeps `pix_in[7:0]`, code 1 keeps `pix_in[9:0]` and code 2 keeps `pix_in[11:0]`. The kept bits are zero-extended on `pix_out`.
- R4: In raw mode, width code 3 is reserved. `pix_vld` stays low and no lines are counted toward interrupts.
- R5: In raw mode with `cfg_fid_inv`=1, `fid_out` is the inverse of `fid_in`. Otherwise `fid_out` follows `fid_in`.
- R6: In raw mode, `line_irq` gives a one-`sclk`-cycle pulse after every `cfg_ivl` captured lines. A line ends when `hsync` falls.
- R7: A frame started in raw mode with `cfg_ivl`=0 raises `cfg_err`, which stays set until reset, and that frame gives no `line_irq`.
- R8: All control inputs are taken only at the `vsync` rising edge. With the channel disabled, `pix_vld`, `sol` and `sof` stay low. Otherwise each frame gives one `sof` and one `sol` per line.
- R9: The line counter restarts at every frame start, so lines from different frames are never added together.
- R10: After reset, `pix_vld`, `sol`, `sof`, `pix_out`, `line_irq` and `cfg_err` are all 0.
- R11: Outside raw mode, the width code, field inversion and interval are ignored: all 12 bits are captured and no `line_irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock |
| prst_n | input | 1 | Active-low asynchronous reset, pixel domain |
| pix_in | input | 12 | Sensor pixel data |
| hsync | input | 1 | Line sync, high during active pixels |
| vsync | input | 1 | Frame sync, rising edge starts a frame |
| fid_in | input | 1 | Field ID from the sensor |
| sclk | input | 1 | System clock |
| srst_n | input | 1 | Active-low asynchronous reset, system domain |
| cfg_en | input | 1 | Channel enable |
| cfg_fall | input | 1 | 1 selects falling-edge capture |
| cfg_raw | input | 1 | 1 selects raw sensor capture mode |
| cfg_width | input | 2 | Pixel width code (0: 8, 1: 10, 2: 12, 3: reserved) |
| cfg_fid_inv | input | 1 | Field ID inversion |
| cfg_ivl | input | 12 | Lines per interrupt |
| pix_out | output | 12 | Captured pixel, zero-extended |
| pix_vld | output | 1 | Pixel valid strobe |
| sol | output | 1 | Start of line, with the line's first valid pixel |
| sof | output | 1 | Start of frame |
| fid_out | output | 1 | Field ID after optional inversion |
| line_irq | output | 1 | Line interrupt pulse, system clock domain |
| cfg_err | output | 1 | Sticky invalid-interval flag |

## Verification
The following properties are checked by assertions on every cycle:
- `pix_vld` never rises under the reserved width.
- Narrow pixels carry no high bits.
- A disabled channel stays silent.
- `sof` and `line_irq` last one cycle.
- `cfg_err` never clears.

Only the directed scenarios can show the rest:
- which clock edge actually sampled the data;
- the exact number of interrupts over a run of lines;
- the counter restart at a frame boundary;
- that a control change made in mid-frame waits for the next frame.

// File: rtl/raw_cap_fe.sv
module raw_cap_fe #(
  parameter int PW = 12,
  parameter int IW = 12
) (
  input  logic          pclk,
  input  logic          prst_n,
  input  logic [PW-1:0] pix_in,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          fid_in,
  input  logic          sclk,
  input  logic          srst_n,
  input  logic          cfg_en,
  input  logic          cfg_fall,
  input  logic          cfg_raw,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_fid_inv,
  input  logic [IW-1:0] cfg_ivl,
  output logic [PW-1:0] pix_out,
  output logic          pix_vld,
  output logic          sol,
  output logic          sof,
  output logic          fid_out,
  output logic          line_irq,
  output logic          cfg_err
);
  localparam int SW = PW + 3;

  logic [SW-1:0] smp_r, smp_f, smp;
  logic          h_q, v_q;
  logic          act_en, act_fall, act_raw, act_inv;
  logic [1:0]    act_w;
  logic [IW-1:0] act_ivl, cnt;
  logic          tog;
  logic [2:0]    sync;

  always_ff @(posedge pclk or negedge prst_n)
    if (!prst_n) smp_r <= '0;
    else         smp_r <= {fid_in, vsync, hsync, pix_in};

  always_ff @(negedge pclk or negedge prst_n)
    if (!prst_n) smp_f <= '0;
    else         smp_f <= {fid_in, vsync, hsync, pix_in};

  assign smp = act_fall ? smp_f : smp_r;

  wire          s_h = smp[PW];
  wire          s_v = smp[PW+1];
  wire          s_f = smp[PW+2];
  wire          fs  = s_v & ~v_q;

  wire          e_en  = fs ? cfg_en      : act_en;
  wire          e_raw = fs ? cfg_raw     : act_raw;
  wire          e_inv = fs ? cfg_fid_inv : act_inv;
  wire [1:0]    e_w   = fs ? cfg_width   : act_w;
  wire [IW-1:0] e_ivl = fs ? cfg_ivl     : act_ivl;

  wire [1:0] wcode = e_raw ? e_w : 2'd2;
  wire       cap   = e_en & (wcode != 2'd3);
  wire       l_end = ~s_h & h_q;
  wire       cnt_on = cap & e_raw & (e_ivl != '0);

  logic [PW-1:0] mask;
  always_comb
    case (wcode)
      2'd0:    mask = PW'((1 << 8) - 1);
      2'd1:    mask = PW'((1 << 10) - 1);
      default: mask = '1;
    endcase

  always_ff @(posedge pclk or negedge prst_n)
    if (!prst_n) begin
      {h_q, v_q} <= '0;
      {act_en, act_fall, act_raw, act_inv} <= '0;
      act_w   <= '0;
      act_ivl <= '0;
      pix_out <= '0;
      {pix_vld, sol, sof, fid_out, cfg_err} <= '0;
      cnt <= '0;
      tog <= 1'b0;
    end else begin
      h_q <= s_h;
      v_q <= s_v;
      if (fs) begin
        act_en   <= cfg_en;
        act_fall <= cfg_fall;
        act_raw  <= cfg_raw;
        act_inv  <= cfg_fid_inv;
        act_w    <= cfg_width;
        act_ivl  <= cfg_ivl;
        if (cfg_raw && cfg_ivl == '0) cfg_err <= 1'b1;
      end
      pix_out <= smp[PW-1:0] & mask;
      pix_vld <= cap & s_h;
      sol     <= cap & s_h & ~h_q;
      sof     <= fs & cfg_en;
      fid_out <= s_f ^ (e_raw & e_inv);
      if (fs) cnt <= '0;
      else if (cnt_on && l_end) begin
        if (cnt == e_ivl - 1'b1) begin
          cnt <= '0;
          tog <= ~tog;
        end else cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge sclk or negedge srst_n)
    if (!srst_n) begin
      sync     <= '0;
      line_irq <= 1'b0;
    end else begin
      sync     <= {sync[1:0], tog};
      line_irq <= sync[2] ^ sync[1];
    end
endmodule

// File: rtl/raw_cap_fe_chk.sv
module raw_cap_fe_chk (
  input logic        pclk,
  input logic        prst_n,
  input logic        sclk,
  input logic        srst_n,
  input logic        pix_vld,
  input logic        sof,
  input logic [11:0] pix_out,
  input logic        line_irq,
  input logic        cfg_err,
  input logic        act_en,
  input logic        act_raw,
  input logic [1:0]  act_w
);
  assert_reserved_novalid_R4: assert property (@(posedge pclk) disable iff (!prst_n)
    (act_raw && act_w == 2'd3) |-> !pix_vld);

  assert_narrow_zero_R3: assert property (@(posedge pclk) disable iff (!prst_n)
    (pix_vld && act_raw && act_w == 2'd0) |-> (pix_out[11:8] == 4'd0));

  assert_err_sticky_R7: assert property (@(posedge pclk) disable iff (!prst_n)
    cfg_err |=> cfg_err);

  assert_disabled_quiet_R8: assert property (@(posedge pclk) disable iff (!prst_n)
    !act_en |-> (!pix_vld && !sof));

  assert_sof_single_R8: assert property (@(posedge pclk) disable iff (!prst_n)
    sof |=> !sof);

  assert_irq_pulse_R6: assert property (@(posedge sclk) disable iff (!srst_n)
    line_irq |=> !line_irq);
endmodule

bind raw_cap_fe raw_cap_fe_chk i_chk (
  .pclk(pclk), .prst_n(prst_n), .sclk(sclk), .srst_n(srst_n),
  .pix_vld(pix_vld), .sof(sof), .pix_out(pix_out), .line_irq(line_irq),
  .cfg_err(cfg_err), .act_en(act_en), .act_raw(act_raw), .act_w(act_w)
);

// File: tb/test_raw_cap_fe.sv
module test_raw_cap_fe;
  logic        pclk = 0, sclk = 0, prst_n = 0, srst_n = 0;
  logic [11:0] pix_in = 0;
  logic        hsync = 0, vsync = 0, fid_in = 0;
  logic        cfg_en = 0, cfg_fall = 0, cfg_raw = 0, cfg_fid_inv = 0;
  logic [1:0]  cfg_width = 0;
  logic [11:0] cfg_ivl = 0;
  logic [11:0] pix_out;
  logic        pix_vld, sol, sof, fid_out, line_irq, cfg_err;

  int n_chk = 0, n_bad = 0;
  int pcnt, solc, sofc, icnt;
  logic [11:0] pfirst;
  logic        fid_last;

  always #5 pclk = ~pclk;
  always #2 sclk = ~sclk;

  raw_cap_fe i_raw_cap_fe (.*);

  always @(posedge pclk) begin
    #1;
    if (pix_vld) begin
      if (pcnt == 0) pfirst = pix_out;
      pcnt++;
      fid_last = fid_out;
    end
    if (sol) solc++;
    if (sof) sofc++;
  end

  always @(posedge sclk) begin
    #1;
    if (line_irq) icnt++;
  end

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cyc(input logic h, input logic v, input logic [11:0] a, input logic [11:0] b);
    @(posedge pclk);
    #2; hsync = h; vsync = v; pix_in = a;
    #5; pix_in = b;
  endtask

  task automatic frame(input int nl, input int np, input logic f, input int mid_w);
    pcnt = 0; solc = 0; sofc = 0; icnt = 0; pfirst = 0; fid_in = f;
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    if (mid_w >= 0) cfg_width = mid_w[1:0];
    for (int l = 0; l < nl; l++) begin
      for (int j = 0; j < np; j++)
        cyc(1, 0, 12'hA00 + 12'(2*j), 12'hA00 + 12'(2*j+1));
      for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0);
    end
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0);
  endtask

  task automatic setcfg(input logic en, input logic fall, input logic raw,
                        input logic [1:0] w, input logic inv, input logic [11:0] ivl);
    cfg_en = en; cfg_fall = fall; cfg_raw = raw; cfg_width = w;
    cfg_fid_inv = inv; cfg_ivl = ivl;
  endtask

  task automatic t_reset;
    #1;
    check("R10 pix_vld", pix_vld, 0);
    check("R10 sol", sol, 0);
    check("R10 sof", sof, 0);
    check("R10 pix_out", pix_out, 0);
    check("R10 line_irq", line_irq, 0);
    check("R10 cfg_err", cfg_err, 0);
  endtask

  task automatic t_rise;
    setcfg(1, 0, 1, 2, 0, 12'd100);
    frame(2, 4, 0, -1);
    check("R1 count", pcnt, 8);
    check("R1 rising sample", pfirst, 12'hA01);
    check("R8 sol count", solc, 2);
    check("R8 sof count", sofc, 1);
  endtask

  task automatic t_fall;
    setcfg(1, 1, 1, 2, 0, 12'd100);
    frame(1, 4, 0, -1);
    frame(2, 4, 0, -1);
    check("R2 count", pcnt, 8);
    check("R2 falling sample", pfirst, 12'hA00);
    cfg_fall = 0;
    frame(1, 4, 0, -1);
  endtask

  task automatic t_width;
    setcfg(1, 0, 1, 0, 0, 12'd100);
    frame(1, 4, 0, -1);
    check("R3 8-bit", pfirst, 12'h001);
    cfg_width = 1;
    frame(1, 4, 0, -1);
    check("R3 10-bit", pfirst, 12'h201);
  endtask

  task automatic t_reserved;
    setcfg(1, 0, 1, 3, 0, 12'd1);
    frame(3, 4, 0, -1);
    check("R4 no pixels", pcnt, 0);
    check("R4 no irq", icnt, 0);
  endtask

  task automatic t_fid;
    setcfg(1, 0, 1, 2, 1, 12'd100);
    frame(1, 4, 1, -1);
    check("R5 inverted", fid_last, 0);
    cfg_fid_inv = 0;
    frame(1, 4, 1, -1);
    check("R5 passthrough", fid_last, 1);
  endtask

  task automatic t_irq;
    setcfg(1, 0, 1, 2, 0, 12'd3);
    frame(7, 3, 0, -1);
    check("R6 every 3 lines", icnt, 2);
    cfg_ivl = 1;
    frame(3, 3, 0, -1);
    check("R6 every line", icnt, 3);
  endtask

  task automatic t_restart;
    setcfg(1, 0, 1, 2, 0, 12'd3);
    frame(2, 3, 0, -1);
    check("R9 first frame", icnt, 0);
    frame(2, 3, 0, -1);
    check("R9 counter restarted", icnt, 0);
  endtask

  task automatic t_frame_cfg;
    setcfg(1, 0, 1, 2, 0, 12'd100);
    frame(1, 4, 0, 0);
    check("R8 mid-frame width held", pfirst, 12'hA01);
    frame(1, 4, 0, -1);
    check("R8 width at next frame", pfirst, 12'h001);
    cfg_en = 0;
    frame(2, 4, 0, -1);
    check("R8 disabled pixels", pcnt, 0);
    check("R8 disabled sof", sofc, 0);
  endtask

  task automatic t_nonraw;
    setcfg(1, 0, 0, 3, 1, 12'd1);
    frame(2, 4, 1, -1);
    check("R11 count", pcnt, 8);
    check("R11 full width", pfirst, 12'hA01);
    check("R11 fid", fid_last, 1);
    check("R11 no irq", icnt, 0);
  endtask

  task automatic t_zero;
    setcfg(1, 0, 1, 2, 0, 12'd0);
    frame(4, 3, 0, -1);
    check("R7 no irq", icnt, 0);
    check("R7 err set", cfg_err, 1);
    setcfg(1, 0, 1, 2, 0, 12'd1);
    frame(1, 3, 0, -1);
    check("R7 err sticky", cfg_err, 1);
  endtask

  initial begin
    #23; prst_n = 1; srst_n = 1;
    t_reset;
    t_rise;
    t_fall;
    t_width;
    t_reserved;
    t_fid;
    t_irq;
    t_restart;
    t_frame_cfg;
    t_nonraw;
    t_zero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule